// File: doc/BRIEF.md
# Carry-Select Decimal Digit Adder

This cell adds two BCD digits and a decimal carry-in and returns one BCD sum digit and a decimal carry-out. It is purely combinational and is meant to be placed side by side, with the carry-out of one digit feeding the carry-in of the next. Most of its logic does not depend on the carry-in. The carry-in reaches the result through only a 2:1 select and a short final adder.

The two digits are first added in binary, with no carry-in. Two flags come from that 4-bit result and its binary carry. The correction flag is raised when the digit pair already needs a +6 adjustment. The propagate flag is raised when an incoming carry would push the digit over nine. The decimal carry is worked out twice, once for a zero carry-in and once for a one. The real carry-in then picks between the two. A reduced final stage adds the carry-in at bit 0 and adds binary 0110 when the selected carry is one, which gives the sum digit. Both flags are also outputs, so that a lookahead network over a group of digits can use them.

Top module: `bcd_csel_digit`

## Requirements
- R1: For valid digits (each 0..9) and any carry-in, `dsum` equals (a+b+cin) mod 10, coded as a plain 4-bit binary value.
- R2: `dcout` is 1 exactly when a+b+cin is 10 or more.
- R3: `corr` is 1 exactly when a+b is 10 or more, whatever the value of `cin`.
- R4: `prop` is 1 exactly when bit 3 and bit 0 of the 4-bit binary sum (a+b) mod 16 are both 1, whatever the value of `cin`.
- R5: With `cin`=0, `dcout` equals `corr`. With `cin`=1, `dcout` equals `corr` OR `prop`.
- R6: Changing only `cin` leaves `corr` and `prop` unchanged.
- R7: For valid digits, `dsum` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First BCD digit |
| b | input | 4 | Second BCD digit |
| cin | input | 1 | Decimal carry-in |
| dsum | output | 4 | BCD sum digit |
| dcout | output | 1 | Decimal carry-out |
| corr | output | 1 | Correction flag, taken from a+b only |
| prop | output | 1 | Propagate flag, taken from a+b only |

## Verification
The bench tries all 200 valid combinations of the two digits and the carry-in, so the corner cases below are all covered.

- Pairs that sum to exactly 9 with a carry-in of 1. A design that fed the carry-in into the first add, or that dropped the propagate path, would return 10 or leave the carry-out low.
- Pairs whose binary sum is 16 or more, such as 9+9 and 8+8. Here the binary carry alone shows that correction is needed. A correction flag built only from the 4-bit sum would miss these and return a wrong digit.
- Toggling only the carry-in. A flag that wrongly depends on `cin` shows up as a change between the two halves of the sweep.

// File: rtl/bcd_csel_digit.sv
module bcd_csel_digit (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] dsum,
  output logic       dcout,
  output logic       corr,
  output logic       prop
);

  logic [3:0] s;
  logic [4:0] rc;
  logic       k0, k1, k;
  logic [2:0] fc;

  // binary add of the two digits, no carry-in
  assign rc[0] = 1'b0;
  for (genvar i = 0; i < 4; i++) begin : g_bin
    assign s[i]    = a[i] ^ b[i] ^ rc[i];
    assign rc[i+1] = (a[i] & b[i]) | (rc[i] & (a[i] ^ b[i]));
  end

  assign corr = rc[4] | (s[3] & (s[2] | s[1]));
  assign prop = s[3] & s[0];

  // both decimal carries ready before cin arrives
  assign k0 = corr;
  assign k1 = corr | prop;
  assign k  = cin ? k1 : k0;
  assign dcout = k;

  // reduced final adder: cin at bit 0, K at bits 1 and 2
  assign dsum[0] = s[0] ^ cin;
  assign fc[0]   = s[0] & cin;
  assign dsum[1] = s[1] ^ k ^ fc[0];
  assign fc[1]   = (s[1] & k) | (fc[0] & (s[1] ^ k));
  assign dsum[2] = s[2] ^ k ^ fc[1];
  assign fc[2]   = (s[2] & k) | (fc[1] & (s[2] ^ k));
  assign dsum[3] = s[3] ^ fc[2];

endmodule

// File: rtl/bcd_csel_digit_chk.sv
module bcd_csel_digit_chk (
  input logic [3:0] a,
  input logic [3:0] b,
  input logic       cin,
  input logic [3:0] dsum,
  input logic       dcout,
  input logic       corr,
  input logic       prop
);
  logic valid;
  logic [4:0] tot;
  assign valid = (a <= 4'd9) && (b <= 4'd9);
  assign tot   = {1'b0, a} + {1'b0, b} + {4'd0, cin};

  always_comb begin
    if (valid) begin
      a_r7_digit_range: assert (dsum <= 4'd9);
      a_r5_sel_zero: assert (cin || (dcout == corr));
      a_r5_sel_one: assert (!cin || (dcout == (corr | prop)));
      a_r2_carry_total: assert (dcout == (tot >= 5'd10));
      a_r1_digit_total: assert ({1'b0, dsum} + (dcout ? 5'd10 : 5'd0) == tot);
    end
  end
endmodule

bind bcd_csel_digit bcd_csel_digit_chk u_chk (.*);

// File: tb/tb_bcd_csel_digit.sv
module tb_bcd_csel_digit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a = 4'd0, b = 4'd0;
  logic cin = 1'b0;
  logic [3:0] dsum;
  logic dcout, corr, prop;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_csel_digit dut (.a(a), .b(b), .cin(cin), .dsum(dsum), .dcout(dcout),
                      .corr(corr), .prop(prop));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d", req, a, b, cin, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", dsum, 0);
    chk("R2 idle", dcout, 0);
    for (int x = 0; x < 10; x++) begin
      for (int y = 0; y < 10; y++) begin
        int lv, pv;
        lv = (x + y >= 10) ? 1 : 0;
        pv = ((((x + y) % 16) & 9) == 9) ? 1 : 0;
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a = 4'(x); b = 4'(y); cin = 1'(c);
          @(negedge clk);
          chk("R1", dsum, (x + y + c) % 10);
          chk("R2", dcout, (x + y + c >= 10) ? 1 : 0);
          chk("R3", corr, lv);
          chk("R4", prop, pv);
          chk("R5", dcout, (c == 0) ? lv : (lv | pv));
          chk("R7", (dsum <= 4'd9) ? 1 : 0, 1);
        end
        // R6: flip only cin and observe the flags again
        @(posedge clk);
        cin = ~cin;
        @(negedge clk);
        chk("R6 corr", corr, lv);
        chk("R6 prop", prop, pv);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule